// File: doc/BRIEF.md
# Event-Reloaded Watchdog Timer

This block is a system watchdog controlled through a byte-wide register port. Software loads a 16-bit count, picks a timebase of seconds or minutes and chooses which peripheral activity keeps the watchdog alive. Keep-alive events can come from a consumer-IR interrupt, mouse activity, keyboard activity or a gameport access. Each enabled event reloads the count after a fixed settling delay. There is no dedicated kick register.

When the count runs out, or when software forces a timeout, the block sets a sticky status bit. It can also pulse a keyboard-reset output and pull a power-good output low, each for a fixed number of clock cycles. The timebase arrives as a one-cycle pulse per second on `tick_i`. A value of zero parks the timer so that it never expires. The register port is a plain write strobe with a combinational read path: it has no handshake and never stalls.

Top module: `sio_wdt`

## Requirements
- R1: After reset all four registers read 0x00, `kbd_rst_o` and `tout_evt_o` are low and `pwr_ok_o` is high.
- R2: Register addresses are 0 = control, 1 = configuration, 2 = value low byte, 3 = value high byte. The configuration and both value bytes read back as written. Control bits 7:4 read back as written, while bits 3:1 always read as 0.
- R3: Writing the low byte loads the counter with {high byte, low byte}. With configuration bit 7 set, each `tick_i` pulse decrements a nonzero count, and the step from 1 to 0 is an expiry that is visible on the outputs right after that clock edge.
- R4: A loaded value of zero stops the timer, so any number of ticks causes no expiry.
- R5: With configuration bit 7 clear, one count lasts MIN_TICKS (default 60) ticks. The tick divider restarts whenever the count is loaded.
- R6: Control bits 7, 6, 5 and 4 enable reload on `ev_cir_i`, `ev_mouse_i`, `ev_kbd_i` and `ev_game_i` respectively. An enabled event on a running timer reloads the count from the value registers RELOAD_DLY cycles later. A disabled event has no effect, and ticks inside the delay window still decrement the count.
- R7: Writing the control register with bit 1 set causes an immediate expiry and leaves the count at zero. Bit 1 is not stored.
- R8: Expiry sets control bit 0. The bit stays set until a control write with bit 0 equal to 0, and a control write with bit 0 equal to 1 leaves it set.
- R9: On expiry, `kbd_rst_o` goes high for PULSE_LEN (16) cycles if configuration bit 6 is set, and `pwr_ok_o` goes low for PULSE_LEN cycles if configuration bit 4 is set. `tout_evt_o` pulses for one cycle if configuration bit 5 is set. An expiry during an active pulse does not extend that pulse. Configuration bits 3:0 are stored only.
- R10: After expiry the count stays at zero and reload events are ignored until the low byte is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tick_i | input | 1 | One-cycle pulse per second |
| ev_cir_i | input | 1 | Consumer-IR interrupt event pulse |
| ev_mouse_i | input | 1 | Mouse activity event pulse |
| ev_kbd_i | input | 1 | Keyboard activity event pulse |
| ev_game_i | input | 1 | Gameport access event pulse |
| kbd_rst_o | output | 1 | Keyboard reset pulse, active high |
| pwr_ok_o | output | 1 | Power-good, driven low during an expiry pulse |
| tout_evt_o | output | 1 | One-cycle timeout event |

## Verification
A wrong count or a wrong divider phase never appears directly at the ports. It shows up as an expiry one tick early or one tick late, so the checks place the expiry on the exact tick and confirm that the previous tick produced nothing. A reload that is lost, arrives early or is taken from a disabled source shifts the expiry by whole ticks, which becomes visible within a few ticks of the event. A status or pulse fault shows on the control readback or on the reset outputs in the cycle right after the expiring edge, and the pulse width is measured cycle by cycle.

// File: rtl/sio_wdt_pkg.sv
package sio_wdt_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_CFG    = 2'd1,
    REG_VAL_LO = 2'd2,
    REG_VAL_HI = 2'd3
  } wdt_reg_e;

  // control register bit positions
  localparam int CTL_SRC_LSB = 4;   // bits 7:4 = cir, mouse, kbd, game
  localparam int CTL_FORCE   = 1;
  localparam int CTL_STATUS  = 0;

  // configuration register bit positions
  localparam int CFG_SEC  = 7;
  localparam int CFG_KRST = 6;
  localparam int CFG_TOUT = 5;
  localparam int CFG_PWR  = 4;

  localparam int NUM_SRC = 4;
endpackage

// File: rtl/sio_wdt_timebase.sv
module sio_wdt_timebase #(
  parameter int MIN_TICKS = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  input  logic sec_mode_i,
  output logic step_o
);
  localparam int PW = (MIN_TICKS > 1) ? $clog2(MIN_TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(MIN_TICKS - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
    end else if (tick_i && !sec_mode_i) begin
      pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    end
  end

  assign step_o = tick_i && (sec_mode_i || (pre_q == PRE_LAST));
endmodule

// File: rtl/sio_wdt_reload_dly.sv
module sio_wdt_reload_dly #(
  parameter int DLY  = 250000,
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            arm_i,
  output logic            fire_o
);
  localparam int DW = $clog2(DLY + 1);
  localparam logic [DW-1:0] DLY_INIT = DW'(DLY - 1);

  logic          pend_q;
  logic [DW-1:0] dly_q;
  logic          hit;

  assign hit    = (|(ev_i & en_i)) && arm_i;
  assign fire_o = pend_q && (dly_q == '0) && arm_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dly_q  <= '0;
    end else if (!arm_i) begin
      pend_q <= 1'b0;
      dly_q  <= '0;
    end else if (pend_q) begin
      if (dly_q == '0) pend_q <= 1'b0;
      else             dly_q  <= dly_q - 1'b1;
    end else if (hit) begin
      pend_q <= 1'b1;
      dly_q  <= DLY_INIT;
    end
  end
endmodule

// File: rtl/sio_wdt_pulse.sv
module sio_wdt_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic out_o
);
  localparam int LW = $clog2(LEN + 1);
  localparam logic [LW-1:0] LEN_V = LW'(LEN);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (trig_i) begin
      cnt_q <= LEN_V;
    end
  end

  assign out_o = (cnt_q != '0);
endmodule

// File: rtl/sio_wdt.sv
module sio_wdt
  import sio_wdt_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RELOAD_DLY = 250000,
  parameter int PULSE_LEN  = 16,
  parameter int MIN_TICKS  = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_i,
  input  logic              ev_cir_i,
  input  logic              ev_mouse_i,
  input  logic              ev_kbd_i,
  input  logic              ev_game_i,
  output logic              kbd_rst_o,
  output logic              pwr_ok_o,
  output logic              tout_evt_o
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [NUM_SRC-1:0] src_en_q;
  logic               status_q;
  logic [DATA_W-1:0]  cfg_q;
  logic [DATA_W-1:0]  lo_q;
  logic [DATA_W-1:0]  hi_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               tout_q;

  logic wr_ctrl, wr_cfg, wr_lo, wr_hi;
  logic force_req, running, step, reload_fire, expire, tb_clr;
  logic [NUM_SRC-1:0] ev_vec;
  logic [1:0] pulse_trig, pulse_act;

  assign wr_ctrl   = reg_wr && (reg_addr == REG_CTRL);
  assign wr_cfg    = reg_wr && (reg_addr == REG_CFG);
  assign wr_lo     = reg_wr && (reg_addr == REG_VAL_LO);
  assign wr_hi     = reg_wr && (reg_addr == REG_VAL_HI);
  assign force_req = wr_ctrl && reg_wdata[CTL_FORCE];
  assign running   = (cnt_q != '0);
  assign ev_vec    = {ev_cir_i, ev_mouse_i, ev_kbd_i, ev_game_i};
  assign tb_clr    = wr_lo || reload_fire || !running;

  sio_wdt_timebase #(.MIN_TICKS(MIN_TICKS)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (tb_clr),
    .tick_i     (tick_i),
    .sec_mode_i (cfg_q[CFG_SEC]),
    .step_o     (step)
  );

  sio_wdt_reload_dly #(.DLY(RELOAD_DLY), .NSRC(NUM_SRC)) u_rld (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_i   (ev_vec),
    .en_i   (src_en_q),
    .arm_i  (running),
    .fire_o (reload_fire)
  );

  assign expire = force_req ||
                  (running && step && (cnt_q == CNT_ONE) && !wr_lo && !reload_fire);

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en_q <= '0;
      cfg_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      if (wr_ctrl) src_en_q <= reg_wdata[CTL_SRC_LSB +: NUM_SRC];
      if (wr_cfg)  cfg_q    <= reg_wdata;
      if (wr_lo)   lo_q     <= reg_wdata;
      if (wr_hi)   hi_q     <= reg_wdata;
    end
  end

  // sticky status: set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else if (expire) begin
      status_q <= 1'b1;
    end else if (wr_ctrl && !reg_wdata[CTL_STATUS]) begin
      status_q <= 1'b0;
    end
  end

  // down-counter: force > load > reload > decrement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (force_req) begin
      cnt_q <= '0;
    end else if (wr_lo) begin
      cnt_q <= {hi_q, reg_wdata};
    end else if (reload_fire) begin
      cnt_q <= {hi_q, lo_q};
    end else if (running && step) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tout_q <= 1'b0;
    else        tout_q <= expire && cfg_q[CFG_TOUT];
  end

  assign pulse_trig[0] = expire && cfg_q[CFG_KRST];
  assign pulse_trig[1] = expire && cfg_q[CFG_PWR];

  for (genvar g = 0; g < 2; g++) begin : g_pulse
    sio_wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (pulse_trig[g]),
      .out_o  (pulse_act[g])
    );
  end

  assign kbd_rst_o  = pulse_act[0];
  assign pwr_ok_o   = !pulse_act[1];
  assign tout_evt_o = tout_q;

  always_comb begin
    unique case (reg_addr)
      REG_CTRL:   reg_rdata = {src_en_q, 3'b000, status_q};
      REG_CFG:    reg_rdata = cfg_q;
      REG_VAL_LO: reg_rdata = lo_q;
      default:    reg_rdata = hi_q;
    endcase
  end
endmodule

// File: rtl/sio_wdt_chk.sv
module sio_wdt_chk #(
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             force_req,
  input logic             wr_lo,
  input logic             reload_fire,
  input logic             status_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cfg_krst,
  input logic             cfg_pwr,
  input logic             kbd_rst_o,
  input logic             pwr_ok_o
);
  localparam int HW = $clog2(PULSE_LEN + 2);
  logic [HW-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_len <= '0;
    else if (kbd_rst_o) hi_len <= hi_len + 1'b1;
    else                hi_len <= '0;
  end

  // R8
  status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> ($past(force_req) || ($past(cnt_q) == CNT_W'(1))));

  // R9
  kbd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kbd_rst_o) |-> (status_q && cfg_krst));

  // R9
  pwr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_ok_o) |-> (status_q && cfg_pwr));

  // R9
  kbd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_len <= HW'(PULSE_LEN));

  // R10
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && !wr_lo) |=> (cnt_q == '0));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q != '0) && !tick_i && !wr_lo && !force_req && !reload_fire) |=> $stable(cnt_q));

  // R7
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_req |=> (status_q && (cnt_q == '0)));
endmodule

bind sio_wdt sio_wdt_chk #(.CNT_W(2 * DATA_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .force_req   (force_req),
  .wr_lo       (wr_lo),
  .reload_fire (reload_fire),
  .status_q    (status_q),
  .cnt_q       (cnt_q),
  .cfg_krst    (cfg_q[6]),
  .cfg_pwr     (cfg_q[4]),
  .kbd_rst_o   (kbd_rst_o),
  .pwr_ok_o    (pwr_ok_o)
);

// File: tb/sio_wdt_tb.sv
`timescale 1ns/1ps
module sio_wdt_tb;
  localparam int DLY = 8;
  localparam int PLEN = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       tick_i = 1'b0;
  logic       ev_cir_i = 1'b0, ev_mouse_i = 1'b0, ev_kbd_i = 1'b0, ev_game_i = 1'b0;
  logic       kbd_rst_o, pwr_ok_o, tout_evt_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sio_wdt #(.RELOAD_DLY(DLY), .PULSE_LEN(PLEN), .MIN_TICKS(60)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_i(tick_i),
    .ev_cir_i(ev_cir_i), .ev_mouse_i(ev_mouse_i), .ev_kbd_i(ev_kbd_i),
    .ev_game_i(ev_game_i), .kbd_rst_o(kbd_rst_o), .pwr_ok_o(pwr_ok_o),
    .tout_evt_o(tout_evt_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(req, {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] v);
    wr(2'd3, v[15:8]);
    wr(2'd2, v[7:0]);
  endtask

  task automatic t_reset;
    rd_chk(2'd0, 8'h00, "R1 ctrl");
    rd_chk(2'd1, 8'h00, "R1 cfg");
    rd_chk(2'd2, 8'h00, "R1 lo");
    rd_chk(2'd3, 8'h00, "R1 hi");
    chk("R1 kbd", {15'd0, kbd_rst_o}, 16'd0);
    chk("R1 pwr", {15'd0, pwr_ok_o}, 16'd1);
    chk("R1 tout", {15'd0, tout_evt_o}, 16'd0);
  endtask

  task automatic t_regs;
    wr(2'd1, 8'hA5); rd_chk(2'd1, 8'hA5, "R2 cfg");
    wr(2'd0, 8'hFC); rd_chk(2'd0, 8'hF0, "R2 ctrl low bits");
    wr(2'd0, 8'h00);
    load(16'h1234);
    rd_chk(2'd2, 8'h34, "R2 lo");
    rd_chk(2'd3, 8'h12, "R2 hi");
    load(16'h0000);
  endtask

  task automatic t_secs;
    wr(2'd1, 8'hF0);
    load(16'd5);
    ticks(4);
    chk("R3 no early expiry", {15'd0, kbd_rst_o}, 16'd0);
    rd_chk(2'd0, 8'h00, "R8 status before expiry");
    ticks(1);
    chk("R3 expiry kbd", {15'd0, kbd_rst_o}, 16'd1);
    chk("R9 pwr low", {15'd0, pwr_ok_o}, 16'd0);
    chk("R9 tout", {15'd0, tout_evt_o}, 16'd1);
    rd_chk(2'd0, 8'h01, "R8 status set");
    @(negedge clk);
    chk("R9 tout one cycle", {15'd0, tout_evt_o}, 16'd0);
    for (int i = 2; i < PLEN; i++) @(negedge clk);
    chk("R9 kbd last cycle", {15'd0, kbd_rst_o}, 16'd1);
    @(negedge clk);
    chk("R9 kbd ends", {15'd0, kbd_rst_o}, 16'd0);
    chk("R9 pwr ends", {15'd0, pwr_ok_o}, 16'd1);
    ticks(10);
    chk("R10 no re-expiry", {15'd0, kbd_rst_o}, 16'd0);
    wr(2'd0, 8'h01);
    rd_chk(2'd0, 8'h01, "R8 write 1 keeps");
    wr(2'd0, 8'h00);
    rd_chk(2'd0, 8'h00, "R8 clear");
  endtask

  task automatic t_zero;
    wr(2'd1, 8'hD0);
    load(16'd0);
    ticks(100);
    chk("R4 no expiry", {15'd0, kbd_rst_o}, 16'd0);
    rd_chk(2'd0, 8'h00, "R4 status clear");
  endtask

  task automatic t_mask;
    wr(2'd1, 8'hA3);
    load(16'd2);
    ticks(2);
    rd_chk(2'd0, 8'h01, "R9 status w/o outputs");
    chk("R9 kbd masked", {15'd0, kbd_rst_o}, 16'd0);
    chk("R9 pwr masked", {15'd0, pwr_ok_o}, 16'd1);
    chk("R9 tout enabled", {15'd0, tout_evt_o}, 16'd1);
    rd_chk(2'd1, 8'hA3, "R9 route field stored");
    wr(2'd0, 8'h00);
  endtask

  task automatic t_min;
    wr(2'd1, 8'h40);
    load(16'd2);
    ticks(119);
    chk("R5 minutes not yet", {15'd0, kbd_rst_o}, 16'd0);
    ticks(1);
    chk("R5 minutes expiry", {15'd0, kbd_rst_o}, 16'd1);
    idle(PLEN + 2);
    wr(2'd0, 8'h00);
  endtask

  task automatic pulse_ev(input int which);
    @(negedge clk);
    case (which)
      0: ev_cir_i = 1'b1;
      1: ev_mouse_i = 1'b1;
      2: ev_kbd_i = 1'b1;
      default: ev_game_i = 1'b1;
    endcase
    @(negedge clk);
    ev_cir_i = 1'b0; ev_mouse_i = 1'b0; ev_kbd_i = 1'b0; ev_game_i = 1'b0;
  endtask

  task automatic t_reload;
    wr(2'd1, 8'hC0);
    wr(2'd0, 8'h40);
    load(16'd5);
    ticks(3);
    pulse_ev(2);
    idle(DLY + 4);
    ticks(1);
    chk("R6 disabled source ignored", {15'd0, kbd_rst_o}, 16'd0);
    pulse_ev(1);
    idle(DLY + 4);
    ticks(4);
    chk("R6 reloaded no expiry", {15'd0, kbd_rst_o}, 16'd0);
    ticks(1);
    chk("R6 expiry after reload", {15'd0, kbd_rst_o}, 16'd1);
    idle(PLEN + 2);
    wr(2'd0, 8'h40);
    load(16'd2);
    pulse_ev(1);
    ticks(2);
    chk("R6 delay window", {15'd0, kbd_rst_o}, 16'd1);
    idle(PLEN + 2);
    pulse_ev(1);
    idle(DLY + 4);
    ticks(5);
    chk("R10 event after expiry", {15'd0, kbd_rst_o}, 16'd0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_force;
    wr(2'd1, 8'hD0);
    load(16'd100);
    wr(2'd0, 8'h02);
    chk("R7 force kbd", {15'd0, kbd_rst_o}, 16'd1);
    chk("R7 force pwr", {15'd0, pwr_ok_o}, 16'd0);
    rd_chk(2'd0, 8'h01, "R7 status, bit1 unstored");
    idle(PLEN + 2);
    ticks(100);
    chk("R7 count left at zero", {15'd0, kbd_rst_o}, 16'd0);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_secs();
    t_zero();
    t_mask();
    t_min();
    t_reload();
    t_force();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule